// File: doc/BRIEF.md
# Paired-Page Translation Buffer with Access Checks

This block is a small fully associative translation buffer. Every entry covers two adjacent 4 KB virtual pages, an even one and an odd one, under one shared tag. For each of the two pages the entry holds its own frame number and its own permission bits. Software fills entries through three staging words. The high word carries the tag and the address-space ID. Each of the two low words describes one page of the pair. An indexed write or a random write copies the staging words into the array. An indexed read copies an entry back into the staging words.

The lookup port is combinational. It takes a virtual address, an address-space ID and an access kind, and it returns either a physical address or an exception code. A page marked valid still refuses a load when its read-inhibit bit is set, and still refuses a fetch when its execute-inhibit bit is set. Each entry holds a single global flag. It is formed at write time as the AND of the two low words' global bits. When the flag is set, the address-space ID is not compared.

Top module: `ptlb_top`

## Requirements
- R1: After reset all three staging words read as zero.
- R2: Staging writes are read back. Bits 29:26 of both low words always read as zero. In the high word only bits 31:13 (tag) and 7:0 (ID) are kept, and the other bits read as zero.
- R3: A low word has this layout: bit 31 read-inhibit, bit 30 execute-inhibit, bits 25:6 frame number, bits 5:3 cache attribute, bit 2 dirty, bit 1 valid, bit 0 global. On a hit with no exception the physical address is {frame, vaddr[11:0]}. Virtual address bits 31:13 are compared with the tag, and bit 12 picks the even page (0) or the odd page (1).
- R4: When no entry matches, the exception code is 1 (refill). For every nonzero exception code the physical address output is zero. Exception codes are 0 none, 1 refill, 2 invalid, 3 modified. Access codes are 0 load, 1 store, 2 fetch.
- R5: Any access to the selected page while its valid bit is clear returns code 2 (invalid). Each page of a pair has its own valid bit.
- R6: A load to a page with read-inhibit set returns code 2, and so does a fetch to a page with execute-inhibit set, even when the page is valid.
- R7: A store to a valid page whose dirty bit is clear returns code 3 (modified). A store to a page with dirty set succeeds. The invalid code has priority over the modified code.
- R8: The entry's global flag is the AND of the two low words' global bits at write time. When the flag is set, the address-space ID is not compared. When it is clear, a different ID misses.
- R9: An indexed read loads the entry's tag and ID into the high word, and each page into its low word, with the entry's global flag copied into bit 0 of both low words.
- R10: A random write stores to the entry selected by a 4-bit counter. The counter is zero while reset is held, increments by one on every clock after reset and wraps modulo 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stg_lo0_we | input | 1 | Write even-page staging word |
| stg_lo1_we | input | 1 | Write odd-page staging word |
| stg_hi_we | input | 1 | Write tag/ID staging word |
| stg_wdata | input | 32 | Data for staging writes |
| stg_lo0_q | output | 32 | Even-page staging word |
| stg_lo1_q | output | 32 | Odd-page staging word |
| stg_hi_q | output | 32 | Tag/ID staging word |
| cmd_wr_idx | input | 1 | Write staging words into entry cmd_index |
| cmd_wr_rand | input | 1 | Write staging words into the entry picked by the counter |
| cmd_rd_idx | input | 1 | Load entry cmd_index into the staging words |
| cmd_index | input | 4 | Entry index for the indexed commands |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_asid | input | 8 | Lookup address-space ID |
| lk_acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| lk_paddr | output | 32 | Translated physical address, zero on exception |
| lk_exc | output | 2 | Exception code |

## Verification
The hardest thing to observe is where a random write lands, because the counter is not visible at any port. The bench keeps its own count of clocks since reset. It captures that count on the edge that issues the random write. It then does an indexed read of the predicted entry and compares the tag that comes back. A second hard case is a pair whose two global bits disagree. The bench uses such a pair to show that the combined flag is clear: a different address-space ID misses, and the readback shows bit 0 cleared in both words.

// File: rtl/ptlb_pkg.sv
package ptlb_pkg;
  localparam int VPN_W  = 19;
  localparam int ASID_W = 8;
  localparam int PFN_W  = 20;

  typedef enum logic [1:0] {EXC_NONE = 2'd0, EXC_REFILL = 2'd1, EXC_INVALID = 2'd2, EXC_MODIFIED = 2'd3} exc_e;
  typedef enum logic [1:0] {ACC_LOAD = 2'd0, ACC_STORE = 2'd1, ACC_FETCH = 2'd2} acc_e;

  typedef struct packed {
    logic             rd_inh;
    logic             ex_inh;
    logic [PFN_W-1:0] pfn;
    logic [2:0]       attr;
    logic             dirty;
    logic             valid;
  } page_t;

  typedef struct packed {
    logic [VPN_W-1:0]  vpn2;
    logic [ASID_W-1:0] asid;
    logic              glob;
    page_t             pg0;
    page_t             pg1;
  } entry_t;

  function automatic page_t lo_to_page(input logic [31:0] w);
    page_t p;
    p.rd_inh = w[31];
    p.ex_inh = w[30];
    p.pfn    = w[25:6];
    p.attr   = w[5:3];
    p.dirty  = w[2];
    p.valid  = w[1];
    return p;
  endfunction

  function automatic logic [31:0] page_to_lo(input page_t p, input logic g);
    return {p.rd_inh, p.ex_inh, 4'b0000, p.pfn, p.attr, p.dirty, p.valid, g};
  endfunction

  function automatic logic [1:0] page_check(input page_t p, input logic [1:0] acc);
    if (!p.valid || (acc == ACC_LOAD && p.rd_inh) || (acc == ACC_FETCH && p.ex_inh))
      return EXC_INVALID;
    if (acc == ACC_STORE && !p.dirty)
      return EXC_MODIFIED;
    return EXC_NONE;
  endfunction
endpackage

// File: rtl/ptlb_rand.sv
module ptlb_rand #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [IDX_W-1:0] rnd
);
  always_ff @(posedge clk) begin
    if (!rst_n) rnd <= '0;
    else        rnd <= rnd + 1'b1;
  end
endmodule

// File: rtl/ptlb_array.sv
module ptlb_array
  import ptlb_pkg::*;
#(
  parameter int N     = 16,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  entry_t           wentry,
  output entry_t           ents [N]
);
  for (genvar i = 0; i < N; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n)                           ents[i] <= '0;
      else if (we && widx == IDX_W'(i))     ents[i] <= wentry;
    end
  end
endmodule

// File: rtl/ptlb_match.sv
module ptlb_match
  import ptlb_pkg::*;
#(
  parameter int N = 16
) (
  input  entry_t             ents [N],
  input  logic [31:0]        vaddr,
  input  logic [ASID_W-1:0]  asid,
  input  logic [1:0]         acc,
  output logic [N-1:0]       hit_vec,
  output logic               hit_any,
  output page_t              sel_page,
  output logic [1:0]         exc,
  output logic [31:0]        paddr
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hit_vec[i] = (ents[i].vpn2 == vaddr[31:13]) && (ents[i].glob || ents[i].asid == asid);
  end

  assign hit_any = |hit_vec;

  always_comb begin
    logic found;
    found    = 1'b0;
    sel_page = '0;
    for (int i = 0; i < N; i++) begin
      if (!found && hit_vec[i]) begin
        found    = 1'b1;
        sel_page = vaddr[12] ? ents[i].pg1 : ents[i].pg0;
      end
    end
  end

  always_comb begin
    if (!hit_any) exc = EXC_REFILL;
    else          exc = page_check(sel_page, acc);
    paddr = (exc == EXC_NONE) ? {sel_page.pfn, vaddr[11:0]} : 32'h0;
  end
endmodule

// File: rtl/ptlb_top.sv
module ptlb_top
  import ptlb_pkg::*;
#(
  parameter int N     = 16,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stg_lo0_we,
  input  logic             stg_lo1_we,
  input  logic             stg_hi_we,
  input  logic [31:0]      stg_wdata,
  output logic [31:0]      stg_lo0_q,
  output logic [31:0]      stg_lo1_q,
  output logic [31:0]      stg_hi_q,
  input  logic             cmd_wr_idx,
  input  logic             cmd_wr_rand,
  input  logic             cmd_rd_idx,
  input  logic [IDX_W-1:0] cmd_index,
  input  logic [31:0]      lk_vaddr,
  input  logic [7:0]       lk_asid,
  input  logic [1:0]       lk_acc,
  output logic [31:0]      lk_paddr,
  output logic [1:0]       lk_exc
);
  localparam logic [31:0] HI_MASK = 32'hFFFF_E0FF;

  logic [31:0]      lo0_r, lo1_r, hi_r;
  logic [IDX_W-1:0] rnd;
  logic             arr_we;
  logic [IDX_W-1:0] arr_idx;
  entry_t           arr_wentry;
  entry_t           ents [N];
  entry_t           rd_ent;
  logic [N-1:0]     hit_vec;
  logic             hit_any;
  page_t            sel_page;

  ptlb_rand #(.IDX_W(IDX_W)) u_rand (.clk(clk), .rst_n(rst_n), .rnd(rnd));

  assign arr_we  = cmd_wr_idx | cmd_wr_rand;
  assign arr_idx = cmd_wr_idx ? cmd_index : rnd;

  always_comb begin
    arr_wentry.vpn2 = hi_r[31:13];
    arr_wentry.asid = hi_r[7:0];
    arr_wentry.glob = lo0_r[0] & lo1_r[0];
    arr_wentry.pg0  = lo_to_page(lo0_r);
    arr_wentry.pg1  = lo_to_page(lo1_r);
  end

  ptlb_array #(.N(N), .IDX_W(IDX_W)) u_arr (
    .clk(clk), .rst_n(rst_n), .we(arr_we), .widx(arr_idx),
    .wentry(arr_wentry), .ents(ents)
  );

  assign rd_ent = ents[cmd_index];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo0_r <= '0;
      lo1_r <= '0;
      hi_r  <= '0;
    end else if (cmd_rd_idx) begin
      lo0_r <= page_to_lo(rd_ent.pg0, rd_ent.glob);
      lo1_r <= page_to_lo(rd_ent.pg1, rd_ent.glob);
      hi_r  <= {rd_ent.vpn2, 5'b0, rd_ent.asid};
    end else begin
      if (stg_lo0_we) lo0_r <= stg_wdata & 32'hC3FF_FFFF;
      if (stg_lo1_we) lo1_r <= stg_wdata & 32'hC3FF_FFFF;
      if (stg_hi_we)  hi_r  <= stg_wdata & HI_MASK;
    end
  end

  assign stg_lo0_q = lo0_r;
  assign stg_lo1_q = lo1_r;
  assign stg_hi_q  = hi_r;

  ptlb_match #(.N(N)) u_match (
    .ents(ents), .vaddr(lk_vaddr), .asid(lk_asid), .acc(lk_acc),
    .hit_vec(hit_vec), .hit_any(hit_any), .sel_page(sel_page),
    .exc(lk_exc), .paddr(lk_paddr)
  );
endmodule

// File: rtl/ptlb_chk.sv
module ptlb_chk #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hit_any,
  input logic [1:0]       exc,
  input logic [31:0]      paddr,
  input logic [1:0]       acc,
  input logic [IDX_W-1:0] rnd,
  input logic             rd_cmd,
  input logic [31:0]      lo0_q,
  input logic [31:0]      lo1_q
);
  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lo0_q[29:26] == 4'b0 && lo1_q[29:26] == 4'b0);

  p_miss_refill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_any |-> exc == 2'd1);

  p_exc_paddr_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    exc != 2'd0 |-> paddr == 32'h0);

  p_modified_store_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    exc == 2'd3 |-> acc == 2'd1);

  p_glob_copied_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cmd |=> lo0_q[0] == lo1_q[0]);

  p_counter_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> rnd == $past(rnd) + 1'b1);
endmodule

bind ptlb_top ptlb_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hit_any(hit_any), .exc(lk_exc), .paddr(lk_paddr),
  .acc(lk_acc), .rnd(rnd), .rd_cmd(cmd_rd_idx), .lo0_q(stg_lo0_q), .lo1_q(stg_lo1_q)
);

// File: tb/sim_ptlb_top.sv
module sim_ptlb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        stg_lo0_we = 0, stg_lo1_we = 0, stg_hi_we = 0;
  logic [31:0] stg_wdata = 0;
  logic [31:0] stg_lo0_q, stg_lo1_q, stg_hi_q;
  logic        cmd_wr_idx = 0, cmd_wr_rand = 0, cmd_rd_idx = 0;
  logic [3:0]  cmd_index = 0;
  logic [31:0] lk_vaddr = 0;
  logic [7:0]  lk_asid = 0;
  logic [1:0]  lk_acc = 0;
  logic [31:0] lk_paddr;
  logic [1:0]  lk_exc;

  int checks = 0, errors = 0;
  logic [3:0] bcnt;
  bit done = 0;

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) bcnt <= 0;
    else        bcnt <= bcnt + 4'd1;
  end

  ptlb_top u0 (.*);

  function automatic logic [31:0] mklo(bit ri, bit xi, logic [19:0] pfn, logic [2:0] c, bit d, bit v, bit g);
    return {ri, xi, 4'b0, pfn, c, d, v, g};
  endfunction

  task automatic chk32(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic stage(logic [31:0] lo0, logic [31:0] lo1, logic [31:0] hi);
    @(negedge clk);
    stg_lo0_we = 1; stg_wdata = lo0; @(negedge clk); stg_lo0_we = 0;
    stg_lo1_we = 1; stg_wdata = lo1; @(negedge clk); stg_lo1_we = 0;
    stg_hi_we  = 1; stg_wdata = hi;  @(negedge clk); stg_hi_we  = 0;
  endtask

  task automatic wr_idx(logic [3:0] idx);
    @(negedge clk); cmd_wr_idx = 1; cmd_index = idx; @(negedge clk); cmd_wr_idx = 0;
  endtask

  task automatic rd_idx(logic [3:0] idx);
    @(negedge clk); cmd_rd_idx = 1; cmd_index = idx; @(negedge clk); cmd_rd_idx = 0;
  endtask

  task automatic look(string req, logic [31:0] va, logic [7:0] asid, logic [1:0] acc,
                      logic [1:0] eexc, logic [31:0] epa);
    @(negedge clk);
    lk_vaddr = va; lk_asid = asid; lk_acc = acc;
    #1;
    chk32({req, " exc"}, {30'b0, lk_exc}, {30'b0, eexc});
    chk32({req, " paddr"}, lk_paddr, epa);
  endtask

  task automatic t_reset();
    chk32("R1 lo0", stg_lo0_q, 0);
    chk32("R1 lo1", stg_lo1_q, 0);
    chk32("R1 hi", stg_hi_q, 0);
  endtask

  task automatic t_staging();
    stage(32'hFFFF_FFFF, 32'h3C00_0000, 32'hFFFF_FFFF);
    chk32("R2 lo0 reserved", stg_lo0_q, 32'hC3FF_FFFF);
    chk32("R2 lo1 reserved", stg_lo1_q, 32'h0);
    chk32("R2 hi mask", stg_hi_q, 32'hFFFF_E0FF);
  endtask

  task automatic t_translate();
    stage(mklo(0,0,20'hABCDE,3'd3,1,1,1) | 32'h3C00_0000,
          mklo(0,0,20'h13579,3'd2,0,1,1), {19'h12345, 13'h05});
    wr_idx(4'd2);
    look("R3 even load", {19'h12345, 1'b0, 12'h3A4}, 8'h09, 2'd0, 2'd0, {20'hABCDE, 12'h3A4});
    look("R3 odd load",  {19'h12345, 1'b1, 12'h010}, 8'h09, 2'd0, 2'd0, {20'h13579, 12'h010});
    look("R7 odd store clean", {19'h12345, 1'b1, 12'h010}, 8'h05, 2'd1, 2'd3, 0);
    look("R7 even store dirty", {19'h12345, 1'b0, 12'hFFF}, 8'h05, 2'd1, 2'd0, {20'hABCDE, 12'hFFF});
    look("R4 miss", {19'h54321, 1'b0, 12'h0}, 8'h05, 2'd0, 2'd1, 0);
  endtask

  task automatic t_checks();
    stage(mklo(0,0,20'h11111,3'd0,0,0,1), mklo(1,0,20'h22222,3'd1,1,1,0), {19'h00777, 13'h03});
    wr_idx(4'd5);
    look("R5 even invalid load",  {19'h00777, 1'b0, 12'h0}, 8'h03, 2'd0, 2'd2, 0);
    look("R7 invalid over modified", {19'h00777, 1'b0, 12'h0}, 8'h03, 2'd1, 2'd2, 0);
    look("R6 read-inhibit load", {19'h00777, 1'b1, 12'h4}, 8'h03, 2'd0, 2'd2, 0);
    look("R6 read-inhibit fetch ok", {19'h00777, 1'b1, 12'h4}, 8'h03, 2'd2, 2'd0, {20'h22222, 12'h4});
    look("R8 global clear other asid", {19'h00777, 1'b1, 12'h4}, 8'h04, 2'd2, 2'd1, 0);
    stage(mklo(0,1,20'h33333,3'd0,1,1,0), mklo(0,0,20'h44444,3'd0,1,1,0), {19'h00ABC, 13'h01});
    wr_idx(4'd7);
    look("R6 exec-inhibit fetch", {19'h00ABC, 1'b0, 12'h8}, 8'h01, 2'd2, 2'd2, 0);
    look("R6 exec-inhibit load ok", {19'h00ABC, 1'b0, 12'h8}, 8'h01, 2'd0, 2'd0, {20'h33333, 12'h8});
  endtask

  task automatic t_readback();
    rd_idx(4'd5);
    chk32("R9 lo0", stg_lo0_q, mklo(0,0,20'h11111,3'd0,0,0,0));
    chk32("R9 lo1", stg_lo1_q, mklo(1,0,20'h22222,3'd1,1,1,0));
    chk32("R9 hi", stg_hi_q, {19'h00777, 13'h03});
    rd_idx(4'd2);
    chk32("R9 glob lo1", stg_lo1_q, mklo(0,0,20'h13579,3'd2,0,1,1));
  endtask

  task automatic t_random();
    for (int k = 0; k < 2; k++) begin
      logic [3:0] target;
      logic [31:0] hi;
      hi = {19'h60000 + 19'(k), 13'h0A};
      stage(mklo(0,0,20'h55555,3'd0,1,1,0), mklo(0,0,20'h66666,3'd0,1,1,0), hi);
      repeat (k * 3) @(negedge clk);
      target = bcnt;
      cmd_wr_rand = 1; @(negedge clk); cmd_wr_rand = 0;
      rd_idx(target);
      chk32("R10 random target hi", stg_hi_q, hi);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_staging();
    t_translate();
    t_checks();
    t_readback();
    t_random();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule